// File: doc/BRIEF.md
# PC System Control Port Logic

This block holds the motherboard control and status logic that sits behind a three-port parallel peripheral interface in a PC-class system. Software writes a single control byte (port B). That byte sets the gate of speaker timer channel 2, enables speaker data, drives the keyboard clock line, selects which half of the configuration switches is visible, and can force the keyboard input stage clear. Two read-only views come back to software:

- Port C merges fixed error flags, the state of timer channel 2 and one nibble of the switches.
- Port A returns the received keyboard byte.

The block includes the keyboard byte holding register with its interrupt request. The timer, the keyboard serial receiver and the interrupt controller are outside the block. The receiver hands over a finished byte through a one-cycle load pulse.

Top module: `sysctl_ports`

## Requirements
- R1: After reset the control byte is 0x00. Timer gate, speaker output, keyboard clock and keyboard interrupt are all 0. The keyboard holding register is 0x00 and will accept a byte.
- R2: A control write takes effect at the next clock edge. Control bit 0 drives `tmr_gate`.
- R3: `spkr_out` is the AND of control bit 1 and the timer channel 2 output `tmr_out`.
- R4: Control bit 6 drives `kbd_clk`.
- R5: Port C bits 3:0 show `cfg_sw[7:4]` when control bit 3 is 1, and `cfg_sw[3:0]` when it is 0.
- R6: Port C bits 7 and 6 (parity error and expansion error) always read 0.
- R7: Port C bit 5 always equals `tmr_out`.
- R8: Port C bit 4 equals `tmr_out` when control bit 0 is 1. Otherwise it reads 1.
- R9: When a byte can be accepted and control bit 7 is 0, a `kbd_load` pulse captures `kbd_byte` at that edge and raises `kbd_irq`. After that, further loads are ignored until the register is cleared.
- R10: At the edge where a control write with bit 7 = 1 lands, the holding register clears to 0x00 and `kbd_irq` goes low. The register can then accept a byte again. While bit 7 stays 1, loads are ignored.
- R11: Port A reads 0xFF while control bit 7 is 1. Otherwise it returns the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_wr | input | 1 | Control byte write strobe |
| pb_wdata | input | 8 | Control byte write data |
| tmr_out | input | 1 | Timer channel 2 output |
| cfg_sw | input | 8 | Configuration switch inputs |
| kbd_load | input | 1 | Received keyboard byte valid pulse |
| kbd_byte | input | 8 | Received keyboard byte |
| tmr_gate | output | 1 | Timer channel 2 gate |
| spkr_out | output | 1 | Speaker drive |
| kbd_clk | output | 1 | Keyboard clock line |
| kbd_irq | output | 1 | Keyboard interrupt request |
| pa_data | output | 8 | Port A read data |
| pc_data | output | 8 | Port C read data |

## Verification
The assertions check the following on every cycle:
- The one-edge latency from a control write to the timer gate.
- The speaker never sounds without the timer output.
- Port C bit 4 reads high whenever the gate is low.
- A clearing write always leaves the interrupt low and port A at 0xFF.
- An accepted load raises the interrupt with the captured byte.
- The held byte never changes until a clear.

Only the bench scenarios can show the following:
- Nibble selection against particular switch patterns.
- The reset values.
- A second byte being refused while the interrupt is pending.
- The recovery sequence of clearing, then releasing bit 7, then loading a new byte.

// File: rtl/sysctl_ports.sv
module sysctl_ports (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pb_wr,
  input  logic [7:0] pb_wdata,
  input  logic       tmr_out,
  input  logic [7:0] cfg_sw,
  input  logic       kbd_load,
  input  logic [7:0] kbd_byte,
  output logic       tmr_gate,
  output logic       spkr_out,
  output logic       kbd_clk,
  output logic       kbd_irq,
  output logic [7:0] pa_data,
  output logic [7:0] pc_data
);
  localparam int GATE_B = 0;
  localparam int SPK_B  = 1;
  localparam int HINB_B = 3;
  localparam int KCLK_B = 6;
  localparam int KCLR_B = 7;

  logic [7:0] pb_q, pb_nxt;
  logic [7:0] sreg;
  logic       shift_en;
  logic       irq_q;

  assign pb_nxt = pb_wr ? pb_wdata : pb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_q     <= 8'h00;
      sreg     <= 8'h00;
      shift_en <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      pb_q <= pb_nxt;
      if (pb_nxt[KCLR_B]) begin
        sreg     <= 8'h00;
        shift_en <= 1'b1;
        irq_q    <= 1'b0;
      end else if (kbd_load && shift_en) begin
        sreg     <= kbd_byte;
        shift_en <= 1'b0;
        irq_q    <= 1'b1;
      end
    end
  end

  assign tmr_gate = pb_q[GATE_B];
  assign spkr_out = pb_q[SPK_B] & tmr_out;
  assign kbd_clk  = pb_q[KCLK_B];
  assign kbd_irq  = irq_q;
  assign pa_data  = pb_q[KCLR_B] ? 8'hFF : sreg;
  assign pc_data  = {2'b00, tmr_out, pb_q[GATE_B] ? tmr_out : 1'b1,
                     pb_q[HINB_B] ? cfg_sw[7:4] : cfg_sw[3:0]};
endmodule

// File: rtl/sysctl_ports_chk.sv
module sysctl_ports_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pb_wr,
  input logic [7:0] pb_wdata,
  input logic       tmr_out,
  input logic       kbd_load,
  input logic [7:0] kbd_byte,
  input logic       tmr_gate,
  input logic       spkr_out,
  input logic       kbd_irq,
  input logic [7:0] pa_data,
  input logic [7:0] pc_data,
  input logic [7:0] pb_q,
  input logic [7:0] sreg,
  input logic       shift_en
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr |=> tmr_gate == $past(pb_wdata[0]));
  p_spk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spkr_out |-> tmr_out);
  p_pc4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_gate |-> pc_data[4]);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wr && pb_wdata[7]) |=> (!kbd_irq && pa_data == 8'hFF));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_load && shift_en && !pb_q[7] && !pb_wr) |=> (kbd_irq && pa_data == $past(kbd_byte)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_irq && !(pb_wr && pb_wdata[7])) |=> $stable(sreg));
endmodule

bind sysctl_ports sysctl_ports_chk u_chk (.*);

// File: tb/test_sysctl_ports.sv
module test_sysctl_ports;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pb_wr = 1'b0;
  logic [7:0] pb_wdata = 8'h00;
  logic tmr_out = 1'b0;
  logic [7:0] cfg_sw = 8'h00;
  logic kbd_load = 1'b0;
  logic [7:0] kbd_byte = 8'h00;
  logic tmr_gate, spkr_out, kbd_clk, kbd_irq;
  logic [7:0] pa_data, pc_data;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sysctl_ports i_sysctl_ports (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_pb(input logic [7:0] v);
    @(negedge clk); pb_wr = 1'b1; pb_wdata = v;
    @(negedge clk); pb_wr = 1'b0;
  endtask

  task automatic load_kbd(input logic [7:0] v);
    @(negedge clk); kbd_load = 1'b1; kbd_byte = v;
    @(negedge clk); kbd_load = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 gate", {7'd0, tmr_gate}, 8'h00);
    check("R1 spkr", {7'd0, spkr_out}, 8'h00);
    check("R1 kclk", {7'd0, kbd_clk}, 8'h00);
    check("R1 irq", {7'd0, kbd_irq}, 8'h00);
    check("R1 porta", pa_data, 8'h00);
  endtask

  task automatic t_gate_speaker;
    tmr_out = 1'b1;
    #1 check("R3 spk off when bit1 clear", {7'd0, spkr_out}, 8'h00);
    wr_pb(8'h03);
    check("R2 gate", {7'd0, tmr_gate}, 8'h01);
    check("R3 spk on", {7'd0, spkr_out}, 8'h01);
    tmr_out = 1'b0;
    #1 check("R3 spk follows timer", {7'd0, spkr_out}, 8'h00);
    wr_pb(8'h40);
    check("R4 kclk", {7'd0, kbd_clk}, 8'h01);
    check("R2 gate low", {7'd0, tmr_gate}, 8'h00);
    wr_pb(8'h00);
    check("R4 kclk low", {7'd0, kbd_clk}, 8'h00);
  endtask

  task automatic t_portc;
    cfg_sw = 8'hA5;
    wr_pb(8'h00);
    tmr_out = 1'b0;
    #1 check("R5 R6 R7 R8 lo nibble gate off t0", pc_data, 8'h15);
    tmr_out = 1'b1;
    #1 check("R7 R8 gate off t1", pc_data, 8'h35);
    wr_pb(8'h09);
    check("R5 R8 hi nibble gate on t1", pc_data, 8'h3A);
    tmr_out = 1'b0;
    #1 check("R8 gate on t0", pc_data, 8'h0A);
    cfg_sw = 8'hFF;
    #1 check("R6 error bits zero", pc_data & 8'hC0, 8'h00);
    wr_pb(8'h00);
  endtask

  task automatic t_kbd;
    load_kbd(8'h5C);
    check("R9 irq set", {7'd0, kbd_irq}, 8'h01);
    check("R11 R9 porta byte", pa_data, 8'h5C);
    load_kbd(8'h33);
    check("R9 second byte ignored", pa_data, 8'h5C);
    wr_pb(8'h80);
    check("R10 irq cleared", {7'd0, kbd_irq}, 8'h00);
    check("R11 porta ff", pa_data, 8'hFF);
    load_kbd(8'h77);
    check("R10 load ignored while held irq", {7'd0, kbd_irq}, 8'h00);
    wr_pb(8'h00);
    check("R10 register cleared", pa_data, 8'h00);
    load_kbd(8'h81);
    check("R10 reaccepts", pa_data, 8'h81);
    check("R9 irq again", {7'd0, kbd_irq}, 8'h01);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate_speaker();
    t_portc();
    t_kbd();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule